// File: doc/BRIEF.md
# Temperature-Adaptive DRAM Timing Selector

This block gives a memory controller the four core DRAM timing values: row-to-column delay (tRCD), active-to-precharge time (tRAS), write recovery (tWR) and precharge time (tRP). It holds several timing sets for one memory module. Each set was profiled offline for one temperature band. A temperature sample with a valid strobe picks the band, and the set for that band drives the outputs. In a cool module the cells hold more charge, so a profiled set can cut the timings well below the standard values. Typical reductions are about a sixth on tRCD, a third on tRAS and tRP, and about half on tWR. At or above the hot limit, which defaults to 85 °C, the standard worst-case set always applies.

The selector changes sets in a safe way. A move to a slower set takes effect at once. A move to a faster set waits for the bank-idle input, so that no command in flight is timed with values that are too short. A small hysteresis stops the selector from toggling when the temperature sits at a band limit. If temperature samples stop arriving, a timeout forces the worst-case set. A simple register-write port loads the timing sets, the band limits and the timeout.

Top module: `dram_tset_sel`

## Requirements
- R1: After reset the active set index is 3 (the worst-case set). Every set holds tRCD=14, tRAS=34, tWR=15 and tRP=14. The band limits are 45, 65 and 85, and the timeout is 1000 cycles.
- R2: A write to cfg_addr 0..3 loads timing set k=cfg_addr, with tRCD in wdata[23:18], tRAS in [17:12], tWR in [11:6] and tRP in [5:0]. The timing outputs always show the fields of the set named by act_set.
- R3: A write to cfg_addr 4, 5 or 6 loads band limit 0, 1 or 2 from wdata[7:0]. The band of a temperature T is the number of limits that are less than or equal to T.
- R4: When a valid sample has a band above the active set, the active set becomes that band one cycle later, whatever bank_idle is.
- R5: A valid sample at or above limit 2 (the hot limit) selects set 3 on the next cycle.
- R6: A move to a faster set is requested only when the band of (T+2), saturated at 255, is below the active set. That band is the target. Otherwise a sample that is not slower leaves the set unchanged.
- R7: A requested faster move is applied in the first later cycle that has bank_idle high and no valid sample. A valid sample that arrives in the meantime replaces or cancels the request.
- R8: A write to cfg_addr 7 loads the timeout N from wdata[15:0]. After N consecutive cycles with no valid sample, set 3 is forced on the next cycle and any pending request is dropped. N=0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_vld | input | 1 | Temperature sample strobe |
| temp_c | input | 8 | Module temperature in °C, unsigned |
| bank_idle | input | 1 | High when no bank operation is in flight |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 24 | Configuration write data |
| act_set | output | 2 | Index of the active timing set |
| act_trcd | output | 6 | Active tRCD in cycles |
| act_tras | output | 6 | Active tRAS in cycles |
| act_twr | output | 6 | Active tWR in cycles |
| act_trp | output | 6 | Active tRP in cycles |

## Verification
Directed temperature sequences drive the selector into each band. One sequence steps down through a limit at 44, 43 and 42 °C, which separates the hysteresis threshold from the raw limit. Other sequences hold bank_idle low while a faster request waits and then interrupt that request with a new sample. This separates deferred moves from immediate slower moves and from replaced requests. A timeout of 5 cycles is run against a silent sensor, and a timeout of zero shows that the timeout can be disabled. Random temperatures, strobes, idle patterns, set reloads and timeout values then check that band selection, deferral and timeout interact correctly over thousands of cycles.

// File: rtl/tset_pkg.sv
package tset_pkg;
   // Kind of configuration register reached by an address
   typedef enum logic [1:0] {
      CFG_SET  = 2'd0,
      CFG_LIM  = 2'd1,
      CFG_TMO  = 2'd2,
      CFG_NONE = 2'd3
   } cfg_kind_e;

   // Field slots inside a packed timing set, counted from the LSB
   localparam int FLD_TRP  = 0;
   localparam int FLD_TWR  = 1;
   localparam int FLD_TRAS = 2;
   localparam int FLD_TRCD = 3;
   localparam int NUM_FLD  = 4;
endpackage

// File: rtl/tset_regs.sv
module tset_regs
   import tset_pkg::*;
#(
   parameter int NUM_SETS = 4,
   parameter int TW       = 8,
   parameter int FW       = 6,
   parameter int TO_W     = 16,
   parameter int AW       = 3,
   parameter int WD       = 24,
   parameter int DEF_TRCD = 14,
   parameter int DEF_TRAS = 34,
   parameter int DEF_TWR  = 15,
   parameter int DEF_TRP  = 14,
   parameter int LIM_BASE = 45,
   parameter int LIM_STEP = 20,
   parameter int DEF_TMO  = 1000
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cfg_we,
   input  logic [AW-1:0]                         cfg_addr,
   input  logic [WD-1:0]                         cfg_wdata,
   output logic [NUM_SETS-1:0][NUM_FLD*FW-1:0]   set_q,
   output logic [NUM_SETS-2:0][TW-1:0]           lim_q,
   output logic [TO_W-1:0]                       tmo_q
);
   localparam int SETW    = NUM_FLD * FW;
   localparam int NUM_LIM = NUM_SETS - 1;
   localparam logic [SETW-1:0] SET_RST = {FW'(DEF_TRCD), FW'(DEF_TRAS),
                                          FW'(DEF_TWR),  FW'(DEF_TRP)};

   cfg_kind_e      kind;
   logic [AW-1:0]  lim_idx;

   always_comb begin
      lim_idx = cfg_addr - AW'(NUM_SETS);
      if (int'(cfg_addr) < NUM_SETS)
         kind = CFG_SET;
      else if (int'(cfg_addr) < NUM_SETS + NUM_LIM)
         kind = CFG_LIM;
      else if (int'(cfg_addr) == NUM_SETS + NUM_LIM)
         kind = CFG_TMO;
      else
         kind = CFG_NONE;
   end

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n)
            set_q[s] <= SET_RST;
         else if (cfg_we && kind == CFG_SET && int'(cfg_addr) == s)
            set_q[s] <= cfg_wdata[SETW-1:0];
      end
   end

   for (genvar l = 0; l < NUM_LIM; l++) begin : g_lim
      always_ff @(posedge clk) begin
         if (!rst_n)
            lim_q[l] <= TW'(LIM_BASE + l * LIM_STEP);
         else if (cfg_we && kind == CFG_LIM && int'(lim_idx) == l)
            lim_q[l] <= cfg_wdata[TW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmo_q <= TO_W'(DEF_TMO);
      else if (cfg_we && kind == CFG_TMO)
         tmo_q <= cfg_wdata[TO_W-1:0];
   end
endmodule

// File: rtl/tset_band.sv
module tset_band #(
   parameter int NUM_SETS = 4,
   parameter int TW       = 8,
   parameter int HYST     = 2,
   parameter int SW       = 2
) (
   input  logic [TW-1:0]               temp_c,
   input  logic [NUM_SETS-2:0][TW-1:0] lim_q,
   output logic [SW-1:0]               band_raw,
   output logic [SW-1:0]               band_hys
);
   localparam int NUM_LIM = NUM_SETS - 1;

   logic [TW:0]   hsum;
   logic [TW-1:0] temp_h;
   logic [NUM_LIM-1:0] ge_raw, ge_hys;

   always_comb begin
      hsum   = {1'b0, temp_c} + (TW+1)'(HYST);
      temp_h = hsum[TW] ? {TW{1'b1}} : hsum[TW-1:0];
   end

   for (genvar l = 0; l < NUM_LIM; l++) begin : g_cmp
      assign ge_raw[l] = (temp_c >= lim_q[l]);
      assign ge_hys[l] = (temp_h >= lim_q[l]);
   end

   always_comb begin
      band_raw = '0;
      band_hys = '0;
      for (int l = 0; l < NUM_LIM; l++) begin
         band_raw = band_raw + SW'(ge_raw[l]);
         band_hys = band_hys + SW'(ge_hys[l]);
      end
   end
endmodule

// File: rtl/tset_tmo.sv
module tset_tmo #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            temp_vld,
   input  logic [TO_W-1:0] tmo_q,
   output logic            tmo_evt
);
   logic [TO_W-1:0] cnt;
   logic            armed;

   assign armed   = (tmo_q != '0) && (cnt != tmo_q);
   assign tmo_evt = !temp_vld && armed && (cnt == tmo_q - TO_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (temp_vld)
         cnt <= '0;
      else if (armed)
         cnt <= cnt + TO_W'(1);
   end
endmodule

// File: rtl/tset_ctrl.sv
module tset_ctrl #(
   parameter int NUM_SETS = 4,
   parameter int SW       = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          temp_vld,
   input  logic          bank_idle,
   input  logic          tmo_evt,
   input  logic [SW-1:0] band_raw,
   input  logic [SW-1:0] band_hys,
   output logic [SW-1:0] cur_set
);
   localparam logic [SW-1:0] WORST = SW'(NUM_SETS - 1);

   logic          pend;
   logic [SW-1:0] pend_set;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_set  <= WORST;
         pend     <= 1'b0;
         pend_set <= WORST;
      end else if (temp_vld) begin
         if (band_raw > cur_set) begin
            cur_set <= band_raw;
            pend    <= 1'b0;
         end else if (band_hys < cur_set) begin
            pend     <= 1'b1;
            pend_set <= band_hys;
         end else begin
            pend <= 1'b0;
         end
      end else if (tmo_evt) begin
         cur_set <= WORST;
         pend    <= 1'b0;
      end else if (pend && bank_idle) begin
         cur_set <= pend_set;
         pend    <= 1'b0;
      end
   end
endmodule

// File: rtl/dram_tset_sel.sv
module dram_tset_sel
   import tset_pkg::*;
#(
   parameter int NUM_SETS = 4,
   parameter int TW       = 8,
   parameter int FW       = 6,
   parameter int TO_W     = 16,
   parameter int HYST     = 2,
   parameter int DEF_TRCD = 14,
   parameter int DEF_TRAS = 34,
   parameter int DEF_TWR  = 15,
   parameter int DEF_TRP  = 14,
   parameter int LIM_BASE = 45,
   parameter int LIM_STEP = 20,
   parameter int DEF_TMO  = 1000,
   localparam int SW      = $clog2(NUM_SETS),
   localparam int AW      = $clog2(2 * NUM_SETS),
   localparam int WD      = NUM_FLD * FW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          temp_vld,
   input  logic [TW-1:0] temp_c,
   input  logic          bank_idle,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [WD-1:0] cfg_wdata,
   output logic [SW-1:0] act_set,
   output logic [FW-1:0] act_trcd,
   output logic [FW-1:0] act_tras,
   output logic [FW-1:0] act_twr,
   output logic [FW-1:0] act_trp
);
   if (NUM_SETS < 2) begin : g_bad_sets
      $error("NUM_SETS must be at least 2");
   end
   if (TO_W > WD || TW > WD) begin : g_bad_wd
      $error("limit and timeout fields must fit in cfg_wdata");
   end
   if (HYST < 0 || HYST >= (1 << TW)) begin : g_bad_hyst
      $error("HYST out of range");
   end

   logic [NUM_SETS-1:0][WD-1:0]   set_q;
   logic [NUM_SETS-2:0][TW-1:0]   lim_q;
   logic [TO_W-1:0]               tmo_q;
   logic [SW-1:0]                 band_raw, band_hys;
   logic                          tmo_evt;
   logic [WD-1:0]                 act_vec;

   tset_regs #(
      .NUM_SETS(NUM_SETS), .TW(TW), .FW(FW), .TO_W(TO_W), .AW(AW), .WD(WD),
      .DEF_TRCD(DEF_TRCD), .DEF_TRAS(DEF_TRAS), .DEF_TWR(DEF_TWR),
      .DEF_TRP(DEF_TRP), .LIM_BASE(LIM_BASE), .LIM_STEP(LIM_STEP),
      .DEF_TMO(DEF_TMO)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .set_q(set_q), .lim_q(lim_q), .tmo_q(tmo_q)
   );

   tset_band #(.NUM_SETS(NUM_SETS), .TW(TW), .HYST(HYST), .SW(SW)) u_band (
      .temp_c(temp_c), .lim_q(lim_q), .band_raw(band_raw), .band_hys(band_hys)
   );

   tset_tmo #(.TO_W(TO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .tmo_q(tmo_q),
      .tmo_evt(tmo_evt)
   );

   tset_ctrl #(.NUM_SETS(NUM_SETS), .SW(SW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .bank_idle(bank_idle),
      .tmo_evt(tmo_evt), .band_raw(band_raw), .band_hys(band_hys),
      .cur_set(act_set)
   );

   assign act_vec  = set_q[act_set];
   assign act_trcd = act_vec[FLD_TRCD*FW +: FW];
   assign act_tras = act_vec[FLD_TRAS*FW +: FW];
   assign act_twr  = act_vec[FLD_TWR*FW  +: FW];
   assign act_trp  = act_vec[FLD_TRP*FW  +: FW];
endmodule

// File: rtl/tset_chk.sv
module tset_chk #(
   parameter int NUM_SETS = 4,
   parameter int TW       = 8,
   parameter int SW       = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          temp_vld,
   input logic [TW-1:0] temp_c,
   input logic          bank_idle,
   input logic [SW-1:0] act_set,
   input logic [SW-1:0] band_raw,
   input logic [SW-1:0] band_hys,
   input logic          tmo_evt,
   input logic [TW-1:0] hot_lim
);
   localparam logic [SW-1:0] WORST = SW'(NUM_SETS - 1);

   AST_SLOW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld && band_raw > act_set) |=> (act_set == $past(band_raw))); // R4

   AST_HOT_WORST: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld && temp_c >= hot_lim) |=> (act_set == WORST)); // R5

   AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld && !(band_raw > act_set) && !(band_hys < act_set))
      |=> $stable(act_set)); // R6

   AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_set < $past(act_set)) |-> ($past(bank_idle) && !$past(temp_vld))); // R7

   AST_TMO_WORST: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt |=> (act_set == WORST)); // R8
endmodule

bind dram_tset_sel tset_chk #(.NUM_SETS(NUM_SETS), .TW(TW), .SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_c(temp_c),
   .bank_idle(bank_idle), .act_set(act_set), .band_raw(band_raw),
   .band_hys(band_hys), .tmo_evt(tmo_evt), .hot_lim(lim_q[NUM_SETS-2])
);

// File: tb/dram_tset_sel_tb.sv
module dram_tset_sel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SEED       = 32'h5eed_0a17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        temp_vld = 1'b0;
   logic [7:0]  temp_c = '0;
   logic        bank_idle = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [23:0] cfg_wdata = '0;
   logic [1:0]  act_set;
   logic [5:0]  act_trcd, act_tras, act_twr, act_trp;

   int checks = 0;
   int failures = 0;

   // bench model
   int m_set [4][4];   // [set][0=trcd,1=tras,2=twr,3=trp]
   int m_lim [3];
   int m_tmo, m_cur, m_pend, m_pset, m_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_tset_sel u_dut (
      .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_c(temp_c),
      .bank_idle(bank_idle), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .act_set(act_set), .act_trcd(act_trcd),
      .act_tras(act_tras), .act_twr(act_twr), .act_trp(act_trp)
   );

   function automatic int band_of(int t);
      int b = 0;
      for (int l = 0; l < 3; l++) if (t >= m_lim[l]) b++;
      return b;
   endfunction

   function automatic logic [23:0] pack(int a, int b, int c, int d);
      return {6'(a), 6'(b), 6'(c), 6'(d)};
   endfunction

   task automatic chk(string req, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic chk_out(string req);
      chk(req, int'(act_set), m_cur, "act_set");
      chk(req, int'(act_trcd), m_set[m_cur][0], "trcd");
      chk(req, int'(act_tras), m_set[m_cur][1], "tras");
      chk(req, int'(act_twr),  m_set[m_cur][2], "twr");
      chk(req, int'(act_trp),  m_set[m_cur][3], "trp");
   endtask

   task automatic model_reset();
      for (int s = 0; s < 4; s++) begin
         m_set[s][0] = 14; m_set[s][1] = 34; m_set[s][2] = 15; m_set[s][3] = 14;
      end
      m_lim[0] = 45; m_lim[1] = 65; m_lim[2] = 85;
      m_tmo = 1000; m_cur = 3; m_pend = 0; m_pset = 3; m_cnt = 0;
   endtask

   // One clock: drive inputs, advance model, check after the edge.
   task automatic cyc(input bit vld, input int t, input bit idle,
                      input bit we, input int addr, input logic [23:0] wd,
                      input string req);
      int br, bh, th;
      bit evt;
      temp_vld = vld; temp_c = 8'(t); bank_idle = idle;
      cfg_we = we; cfg_addr = 3'(addr); cfg_wdata = wd;
      br = band_of(t);
      th = (t + 2 > 255) ? 255 : t + 2;
      bh = band_of(th);
      evt = 0;
      if (!vld && m_tmo != 0 && m_cnt != m_tmo) evt = (m_cnt == m_tmo - 1);
      if (vld) begin
         if (br > m_cur) begin m_cur = br; m_pend = 0; end
         else if (bh < m_cur) begin m_pend = 1; m_pset = bh; end
         else m_pend = 0;
      end else if (evt) begin
         m_cur = 3; m_pend = 0;
      end else if (m_pend != 0 && idle) begin
         m_cur = m_pset; m_pend = 0;
      end
      if (vld) m_cnt = 0;
      else if (m_tmo != 0 && m_cnt != m_tmo) m_cnt++;
      if (we) begin
         if (addr < 4) begin
            m_set[addr][0] = int'(wd[23:18]); m_set[addr][1] = int'(wd[17:12]);
            m_set[addr][2] = int'(wd[11:6]);  m_set[addr][3] = int'(wd[5:0]);
         end else if (addr < 7) m_lim[addr-4] = int'(wd[7:0]);
         else m_tmo = int'(wd[15:0]);
      end
      @(posedge clk);
      #1;
      chk_out(req);
   endtask

   task automatic smp(int t, bit idle, string req);
      cyc(1'b1, t, idle, 1'b0, 0, '0, req);
   endtask

   task automatic nop(bit idle, string req);
      cyc(1'b0, 0, idle, 1'b0, 0, '0, req);
   endtask

   task automatic wr(int addr, logic [23:0] wd, string req);
      cyc(1'b0, 0, 1'b0, 1'b1, addr, wd, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int r;
      r = $urandom(SEED);
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      chk_out("R1");                      // reset state
      rst_n = 1'b1;

      // R2: load profiled sets, R3: limits, R8: timeout
      wr(0, pack(11, 21, 7, 9),  "R2");
      wr(1, pack(12, 25, 9, 10), "R2");
      wr(2, pack(13, 30, 12, 12), "R2");
      wr(4, 24'd45, "R3");
      wr(5, 24'd65, "R3");
      wr(6, 24'd85, "R3");
      chk("R1", int'(act_set), 3, "still worst after writes");

      // R7: faster move waits for idle
      smp(50, 1'b0, "R7");
      nop(1'b0, "R7");
      chk("R7", int'(act_set), 3, "held while busy");
      nop(1'b1, "R7");
      chk("R2", int'(act_trcd), 12, "set1 trcd");
      // R4: slower move immediate while busy
      smp(70, 1'b0, "R4");
      chk("R4", int'(act_set), 2, "slower immediate");
      // R5: hot limit
      smp(85, 1'b1, "R5");
      chk("R5", int'(act_set), 3, "hot at limit");
      // R6: hysteresis around limit 45, starting in band 1
      smp(50, 1'b1, "R6");
      nop(1'b1, "R6");
      smp(44, 1'b1, "R6");
      nop(1'b1, "R6");
      smp(43, 1'b1, "R6");
      nop(1'b1, "R6");
      chk("R6", int'(act_set), 1, "no move inside hysteresis");
      smp(42, 1'b1, "R6");
      nop(1'b1, "R6");
      chk("R6", int'(act_set), 0, "move below hysteresis");
      // R7: pending request replaced by newer sample
      smp(90, 1'b1, "R5");
      smp(30, 1'b0, "R7");
      smp(60, 1'b0, "R7");
      nop(1'b1, "R7");
      chk("R7", int'(act_set), 1, "replaced request");
      // R8: timeout of 5 cycles
      wr(7, 24'd5, "R8");
      smp(30, 1'b1, "R8");
      for (int i = 0; i < 6; i++) nop(1'b1, "R8");
      chk("R8", int'(act_set), 3, "timeout forces worst");
      // R8: zero disables
      wr(7, 24'd0, "R8");
      smp(30, 1'b1, "R8");
      for (int i = 0; i < 30; i++) nop(1'b1, "R8");
      chk("R8", int'(act_set), 0, "disabled timeout");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int sel;
         sel = int'($urandom_range(0, 99));
         if (sel < 2) begin
            int a;
            a = int'($urandom_range(0, 3));
            wr(a, 24'($urandom), "R2");
         end else if (sel < 3) begin
            int tv;
            tv = int'($urandom_range(0, 3));
            wr(7, (tv == 0) ? 24'd0 : (tv == 1) ? 24'd3 : (tv == 2) ? 24'd8 : 24'd40, "R8");
         end else if (sel < 28) begin
            smp(int'($urandom_range(20, 100)), 1'($urandom), "R3");
         end else begin
            nop(1'($urandom), "R7");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule